// File: doc/BRIEF.md
# I2C multi-message transaction sequencer

This block drives a byte-level I2C master so that a whole list of messages (a combined transaction) runs without software touching each byte. Messages are described by small descriptors pushed into an internal queue while the sequencer is idle: a 7-bit target address, a direction, a byte count and a flag that suppresses the start condition in front of the message. A `go` pulse launches the transaction. From then on the sequencer issues one command to the byte master, waits for that master's completion pulse, inspects the returned acknowledge and arbitration flags, and decides the next command.

Write data is taken from a byte stream (`tx_data`, consumed on `tx_pop`) and read data is delivered on a byte stream (`rx_valid`, `rx_data`). Between messages a repeated start with the next address is inserted unless the next message asks to run on without one. Every read ends its last byte with a not-acknowledge. After the last message a stop is issued; the completion of that stop is acknowledged and a one-cycle `done` pulse carries the result code. Any not-acknowledge during an address or write phase, or lost arbitration at any time, aborts the transaction through a stop with an error result. A transaction-wide watchdog ends a transaction whose master never answers.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset `busy`, `cmd_valid`, `done`, `tx_pop` and `rx_valid` are all 0.
- R2: A `go` pulse while idle with at least one queued descriptor raises `busy` and, on the next cycle, issues op 1 (start plus write) whose byte is the address shifted left by one with bit 0 set to 1 for a read and 0 for a write.
- R3: In a write message each completion (no NACK, no arbitration loss) that leaves bytes to send issues op 2 (write) carrying the current `tx_data` byte, with a one-cycle `tx_pop` in the same cycle.
- R4: In a read message every completion after a read command delivers `evt_rdata` on `rx_data` with `rx_valid` high; read commands are op 3 (read with ACK) except for the message's last byte, which uses op 4 (read with NACK); a NACK flag on a read completion is ignored.
- R5: When a message's byte count is reached and another message is queued, the sequencer issues op 1 with the next message's address byte, unless that message has its no-start flag set, in which case it goes on with data commands in that message's direction.
- R6: A zero-length message issues no data command: after its address phase (or at once, for a no-start message) the sequencer moves on to the next message.
- R7: After the last message op 5 (stop) is issued; the completion of the stop is answered with op 6 (interrupt acknowledge) in the same cycle as a one-cycle `done` pulse with `result` 0 (success) and `busy` low.
- R8: A NACK on an address or write completion, or lost arbitration on any data completion, issues op 5 at once; the following completion gives op 6 with `done` and `result` 1 (bus error).
- R9: If `TIMEOUT_CYC` cycles pass after `go` without the transaction finishing, `done` pulses with `result` 2 (timeout), `busy` drops and no further command is issued.
- R10: While `busy` is high, `go` pulses and descriptor pushes are ignored; a `go` with an empty queue does nothing.
- R11: Descriptors left in the queue when a transaction ends by error or timeout are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_push | input | 1 | Push a descriptor into the queue (idle only) |
| desc_addr | input | 7 | 7-bit target address of the descriptor |
| desc_rd | input | 1 | 1 for a read message, 0 for a write |
| desc_len | input | LEN_W | Number of data bytes in the message |
| desc_nostart | input | 1 | Run on without a start condition before this message |
| go | input | 1 | Launch a transaction over the queued descriptors |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 2 | 0 success, 1 bus error, 2 timeout; valid with `done` |
| cmd_valid | output | 1 | One-cycle command strobe to the byte master |
| cmd_op | output | 3 | Command: 1 start+write, 2 write, 3 read ACK, 4 read NACK, 5 stop, 6 interrupt acknowledge |
| cmd_byte | output | 8 | Byte to transmit with ops 1 and 2 |
| evt_valid | input | 1 | Completion pulse from the byte master |
| evt_nack | input | 1 | Target did not acknowledge the last byte |
| evt_arblost | input | 1 | Arbitration was lost |
| evt_rdata | input | 8 | Byte received by the last read |
| tx_data | input | 8 | Head of the transmit byte stream |
| tx_pop | output | 1 | Transmit byte consumed |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |

## Verification
The hardest situation to reach is a chain of messages where a no-start message of zero length sits between a write and a no-start read, because the sequencer must walk over the empty message without a command and switch direction with no start in between. The bench reaches it by queuing exactly that three-message list and playing the byte master itself, answering each command after a fixed latency, so the whole command log can be compared. Error and timeout paths are reached the same way, by having the master model flag a NACK or lost arbitration on a chosen completion, or by keeping it silent.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_START_WR  = 3'd1,
        OP_WRITE     = 3'd2,
        OP_READ_ACK  = 3'd3,
        OP_READ_NACK = 3'd4,
        OP_STOP      = 3'd5,
        OP_IACK      = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BUS_ERR = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_WRITE  = 3'd2,
        ST_READ   = 3'd3,
        ST_NEXT   = 3'd4,
        ST_FINISH = 3'd5,
        ST_ABORT  = 3'd6
    } st_e;

    // Address byte on the wire: target address above, direction in bit 0.
    function automatic logic [7:0] addr_byte(input logic [6:0] addr, input logic rd);
        return {addr, rd};
    endfunction

endpackage

// File: rtl/i2cseq_desc_fifo.sv
module i2cseq_desc_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (p_q.cnt == '0);
    assign full    = (p_q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem_q[p_q.rp];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wp = wrap_inc(p_q.wp);
            if (do_pop)  p_d.rp = wrap_inc(p_q.rp);
            p_d.cnt = p_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && p_q.wp == PW'(i)) mem_q[i] <= wdata;
        end
    end

endmodule

// File: rtl/i2cseq_watchdog.sv
module i2cseq_watchdog #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && !arm && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (arm)                           cnt_d = '0;
        else if (run && cnt_q < CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2cseq_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int LEN_W       = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_push,
    input  logic [6:0]       desc_addr,
    input  logic             desc_rd,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_nostart,
    input  logic             go,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    input  logic             evt_valid,
    input  logic             evt_nack,
    input  logic             evt_arblost,
    input  logic [7:0]       evt_rdata,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_valid,
    output logic [7:0]       rx_data
);
    localparam int DW = LEN_W + 9;

    typedef struct packed {
        st_e              state;
        logic             busy;
        logic [6:0]       addr;
        logic             rd;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] pos;
        logic             cmd_valid;
        op_e              cmd_op;
        logic [7:0]       cmd_byte;
        logic             tx_pop;
        logic             rx_valid;
        logic [7:0]       rx_data;
        logic             done;
        res_e             result;
    } regs_t;

    regs_t d, q;

    logic             f_push, f_pop, f_flush, f_empty, f_full;
    logic [DW-1:0]    f_rdata;
    logic [6:0]       h_addr;
    logic             h_rd, h_nostart;
    logic [LEN_W-1:0] h_len;
    logic             wd_arm, wd_expired;
    logic             issue_data;

    assign f_push = desc_push && !q.busy;
    assign {h_nostart, h_rd, h_addr, h_len} = f_rdata;

    i2cseq_desc_fifo #(.DEPTH(QDEPTH), .W(DW)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .wdata ({desc_nostart, desc_rd, desc_addr, desc_len}),
        .pop   (f_pop),
        .flush (f_flush),
        .rdata (f_rdata),
        .empty (f_empty),
        .full  (f_full)
    );

    i2cseq_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (wd_arm),
        .run     (q.busy),
        .expired (wd_expired)
    );

    always_comb begin
        d            = q;
        d.cmd_valid  = 1'b0;
        d.tx_pop     = 1'b0;
        d.rx_valid   = 1'b0;
        d.done       = 1'b0;
        f_pop        = 1'b0;
        f_flush      = 1'b0;
        wd_arm       = 1'b0;
        issue_data   = 1'b0;

        case (q.state)
            ST_IDLE: begin
                // f_full only gates pushes inside the queue
                if (go && !f_empty) begin
                    f_pop      = 1'b1;
                    wd_arm     = 1'b1;
                    d.busy     = 1'b1;
                    d.addr     = h_addr;
                    d.rd       = h_rd;
                    d.len      = h_len;
                    d.pos      = '0;
                    d.state    = ST_START;
                    d.cmd_valid = 1'b1;
                    d.cmd_op   = OP_START_WR;
                    d.cmd_byte = addr_byte(h_addr, h_rd);
                end
            end
            ST_START, ST_WRITE: begin
                if (evt_valid) begin
                    if (evt_arblost || evt_nack) begin
                        d.state     = ST_ABORT;
                        d.cmd_valid = 1'b1;
                        d.cmd_op    = OP_STOP;
                    end else if (q.pos == q.len) begin
                        d.state = ST_NEXT;
                    end else begin
                        issue_data = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (evt_valid) begin
                    if (evt_arblost) begin
                        d.state     = ST_ABORT;
                        d.cmd_valid = 1'b1;
                        d.cmd_op    = OP_STOP;
                    end else begin
                        d.rx_valid = 1'b1;
                        d.rx_data  = evt_rdata;
                        d.pos      = q.pos + 1'b1;
                        if (d.pos == q.len) d.state = ST_NEXT;
                        else                issue_data = 1'b1;
                    end
                end
            end
            ST_NEXT: begin
                if (f_empty) begin
                    d.state     = ST_FINISH;
                    d.cmd_valid = 1'b1;
                    d.cmd_op    = OP_STOP;
                end else begin
                    f_pop  = 1'b1;
                    d.addr = h_addr;
                    d.rd   = h_rd;
                    d.len  = h_len;
                    d.pos  = '0;
                    if (!h_nostart) begin
                        d.state     = ST_START;
                        d.cmd_valid = 1'b1;
                        d.cmd_op    = OP_START_WR;
                        d.cmd_byte  = addr_byte(h_addr, h_rd);
                    end else if (h_len != '0) begin
                        issue_data = 1'b1;
                    end
                end
            end
            ST_FINISH, ST_ABORT: begin
                if (evt_valid) begin
                    d.cmd_valid = 1'b1;
                    d.cmd_op    = OP_IACK;
                    d.done      = 1'b1;
                    d.busy      = 1'b0;
                    d.state     = ST_IDLE;
                    if (q.state == ST_FINISH) begin
                        d.result = RES_OK;
                    end else begin
                        d.result = RES_BUS_ERR;
                        f_flush  = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (issue_data) begin
            d.cmd_valid = 1'b1;
            if (d.rd) begin
                d.state    = ST_READ;
                d.cmd_byte = 8'h00;
                d.cmd_op   = (({1'b0, d.pos} + 1'b1) == {1'b0, d.len}) ? OP_READ_NACK
                                                                         : OP_READ_ACK;
            end else begin
                d.state    = ST_WRITE;
                d.cmd_op   = OP_WRITE;
                d.cmd_byte = tx_data;
                d.tx_pop   = 1'b1;
                d.pos      = d.pos + 1'b1;
            end
        end

        if (wd_expired) begin
            d.state     = ST_IDLE;
            d.busy      = 1'b0;
            d.done      = 1'b1;
            d.result    = RES_TIMEOUT;
            d.cmd_valid = 1'b0;
            d.tx_pop    = 1'b0;
            d.rx_valid  = 1'b0;
            f_pop       = 1'b0;
            f_flush     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign result    = q.result;
    assign cmd_valid = q.cmd_valid;
    assign cmd_op    = q.cmd_op;
    assign cmd_byte  = q.cmd_byte;
    assign tx_pop    = q.tx_pop;
    assign rx_valid  = q.rx_valid;
    assign rx_data   = q.rx_data;

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk
    import i2cseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       tx_pop,
    input logic       rx_valid
);
    // R2
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_valid && cmd_op == OP_START_WR));

    // R3
    tx_pop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (cmd_valid && cmd_op == OP_WRITE));

    // R4
    rx_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R7
    iack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IACK) |-> (done && !busy));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));

    // R10
    busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    idle_cmd_only_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |-> (cmd_op == OP_IACK));

endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .tx_pop    (tx_pop),
    .rx_valid  (rx_valid)
);

// File: tb/tb_i2c_txn_seq.sv
module tb_i2c_txn_seq;
    localparam int LEN_W = 8;
    localparam int TMO   = 300;
    localparam int LAT   = 3;

    localparam logic [2:0] C_START = 3'd1, C_WR = 3'd2, C_RA = 3'd3, C_RN = 3'd4,
                           C_STOP = 3'd5, C_IACK = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             desc_push = 0, desc_rd = 0, desc_nostart = 0, go = 0;
    logic [6:0]       desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic             busy, done, cmd_valid, tx_pop, rx_valid;
    logic [1:0]       result;
    logic [2:0]       cmd_op;
    logic [7:0]       cmd_byte, rx_data, tx_data;
    logic             evt_valid = 0, evt_nack = 0, evt_arblost = 0;
    logic [7:0]       evt_rdata = '0;

    int tx_idx = 0;
    assign tx_data = 8'(8'h50 + tx_idx);

    i2c_txn_seq #(.QDEPTH(4), .LEN_W(LEN_W), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .desc_push(desc_push), .desc_addr(desc_addr),
        .desc_rd(desc_rd), .desc_len(desc_len), .desc_nostart(desc_nostart), .go(go),
        .busy(busy), .done(done), .result(result), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_byte(cmd_byte), .evt_valid(evt_valid),
        .evt_nack(evt_nack), .evt_arblost(evt_arblost), .evt_rdata(evt_rdata),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    int n_chk = 0, n_fail = 0;
    logic [2:0] op_log [32];
    logic [7:0] byte_log [32];
    logic [7:0] rx_log [16];
    int ncmd, nrx, cyc;
    logic [1:0] got_res;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_desc(input logic [6:0] a, input logic rd, input int len, input logic ns);
        @(negedge clk);
        desc_push = 1; desc_addr = a; desc_rd = rd; desc_len = LEN_W'(len); desc_nostart = ns;
        @(negedge clk);
        desc_push = 0;
    endtask

    // Plays the byte master: answers each command LAT cycles later.
    task automatic run_txn(input int nack_at, input int arb_at, input bit silent, input bit poke);
        int pend = 0;
        int evc = 0;
        ncmd = 0; nrx = 0; tx_idx = 0; cyc = -1; got_res = 2'd3;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            go = (c == 0); evt_valid = 0; evt_nack = 0; evt_arblost = 0; desc_push = 0;
            if (poke && c == 6) begin
                go = 1; desc_push = 1; desc_addr = 7'h13; desc_rd = 1; desc_len = 1; desc_nostart = 0;
            end
            if (tx_pop) tx_idx++;
            if (rx_valid && nrx < 16) begin rx_log[nrx] = rx_data; nrx++; end
            if (cmd_valid) begin
                if (ncmd < 32) begin op_log[ncmd] = cmd_op; byte_log[ncmd] = cmd_byte; end
                ncmd++;
                pend = LAT;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0 && !silent) begin
                    evt_valid = 1; evt_nack = (evc == nack_at); evt_arblost = (evc == arb_at);
                    evt_rdata = 8'(8'hA0 + evc);
                    evc++;
                end
            end
            if (done) begin got_res = result; cyc = c; break; end
        end
        @(negedge clk);
        go = 0; evt_valid = 0; evt_nack = 0; evt_arblost = 0; desc_push = 0;
    endtask

    task automatic check_go_ignored(input string req);
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        chk(req, "busy after go with empty queue", int'(busy), 0);
        chk(req, "cmd after go with empty queue", int'(cmd_valid), 0);
    endtask

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic [7:0] len;
        logic [7:0] nack_at;
        logic [7:0] arb_at;
        logic [7:0] ncmd;
        logic [1:0] res;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h50, 1'b0, 8'd3, 8'hFF, 8'hFF, 8'd6, 2'd0},
        '{7'h1A, 1'b1, 8'd4, 8'hFF, 8'hFF, 8'd7, 2'd0},
        '{7'h7F, 1'b0, 8'd0, 8'hFF, 8'hFF, 8'd3, 2'd0},
        '{7'h11, 1'b0, 8'd3, 8'd2,  8'hFF, 8'd5, 2'd1},
        '{7'h22, 1'b1, 8'd2, 8'hFF, 8'd1,  8'd4, 2'd1},
        '{7'h2B, 1'b1, 8'd2, 8'd1,  8'hFF, 8'd5, 2'd0},
        '{7'h00, 1'b1, 8'd1, 8'hFF, 8'hFF, 8'd4, 2'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "cmd_valid", int'(cmd_valid), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "tx_pop|rx_valid", int'(tx_pop | rx_valid), 0);

        // Table of single-message transactions (R2 R3 R4 R6 R7 R8)
        foreach (VECS[v]) begin
            push_desc(VECS[v].addr, VECS[v].rd, int'(VECS[v].len), 1'b0);
            run_txn(int'(VECS[v].nack_at), int'(VECS[v].arb_at), 1'b0, 1'b0);
            chk("R7/R8", "command count", ncmd, int'(VECS[v].ncmd));
            chk("R7/R8", "result", int'(got_res), int'(VECS[v].res));
            chk("R2", "first op", int'(op_log[0]), int'(C_START));
            chk("R2", "address byte", int'(byte_log[0]), int'({VECS[v].addr, VECS[v].rd}));
            if (ncmd >= 2 && ncmd <= 32) begin
                chk("R7", "last op", int'(op_log[ncmd-1]), int'(C_IACK));
                chk("R8", "stop before ack", int'(op_log[ncmd-2]), int'(C_STOP));
            end
            if (VECS[v].res == 2'd0) begin
                for (int k = 1; k <= int'(VECS[v].len); k++) begin
                    if (VECS[v].rd) begin
                        chk("R4", "read op", int'(op_log[k]),
                            (k == int'(VECS[v].len)) ? int'(C_RN) : int'(C_RA));
                        chk("R4", "rx byte", int'(rx_log[k-1]), 8'hA0 + k);
                    end else begin
                        chk("R3", "write op", int'(op_log[k]), int'(C_WR));
                        chk("R3", "write byte", int'(byte_log[k]), 8'h50 + k - 1);
                    end
                end
                if (VECS[v].rd) chk("R4", "rx count", nrx, int'(VECS[v].len));
                else            chk("R3", "tx pops", tx_idx, int'(VECS[v].len));
            end
        end

        // R5 repeated start between messages
        push_desc(7'h21, 1'b0, 2, 1'b0);
        push_desc(7'h21, 1'b1, 2, 1'b0);
        run_txn(-1, -1, 1'b0, 1'b0);
        chk("R5", "command count", ncmd, 8);
        chk("R5", "second start op", int'(op_log[3]), int'(C_START));
        chk("R5", "second address byte", int'(byte_log[3]), 8'h43);
        chk("R5", "last read op", int'(op_log[5]), int'(C_RN));
        chk("R5", "rx second byte", int'(rx_log[1]), 8'hA5);
        chk("R7", "result", int'(got_res), 0);

        // R5 no-start continues the data phase
        push_desc(7'h30, 1'b0, 1, 1'b0);
        push_desc(7'h31, 1'b0, 2, 1'b1);
        run_txn(-1, -1, 1'b0, 1'b0);
        chk("R5", "no-start command count", ncmd, 6);
        chk("R5", "no-start op", int'(op_log[2]), int'(C_WR));
        chk("R5", "no-start last byte", int'(byte_log[3]), 8'h52);

        // R6 zero-length no-start message between write and no-start read
        push_desc(7'h31, 1'b0, 1, 1'b0);
        push_desc(7'h05, 1'b1, 0, 1'b1);
        push_desc(7'h06, 1'b1, 1, 1'b1);
        run_txn(-1, -1, 1'b0, 1'b0);
        chk("R6", "command count", ncmd, 5);
        chk("R6", "direct read after write", int'(op_log[2]), int'(C_RN));
        chk("R6", "rx byte", int'(rx_log[0]), 8'hA2);
        chk("R6", "result", int'(got_res), 0);

        // R8 address NACK aborts, R11 remaining descriptor discarded
        push_desc(7'h40, 1'b0, 1, 1'b0);
        push_desc(7'h41, 1'b1, 2, 1'b0);
        run_txn(0, -1, 1'b0, 1'b0);
        chk("R8", "command count", ncmd, 3);
        chk("R8", "result", int'(got_res), 1);
        check_go_ignored("R11");

        // R10 go and push ignored while busy
        push_desc(7'h12, 1'b0, 1, 1'b0);
        run_txn(-1, -1, 1'b0, 1'b1);
        chk("R10", "command count", ncmd, 4);
        chk("R10", "result", int'(got_res), 0);
        check_go_ignored("R10");

        // R9 watchdog when the master never answers
        push_desc(7'h44, 1'b1, 1, 1'b0);
        run_txn(-1, -1, 1'b1, 1'b0);
        chk("R9", "result", int'(got_res), 2);
        chk("R9", "command count", ncmd, 1);
        chk("R9", "expiry window", int'(cyc >= TMO - 5 && cyc <= TMO + 5), 1);
        chk("R9", "busy after timeout", int'(busy), 0);
        check_go_ignored("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule